// File: doc/BRIEF.md
# Peripheral Control Register Slave with Requester ID Return

This block is a bank of 32-bit control registers that sits on a request/grant peripheral port. A master raises a request with a word address, a read/write select, four byte enables, write data and an ID naming itself. The slave grants at once, combinationally from the request. The slave then answers every accepted request, read or write, with a response strobe one cycle later.

Each response carries the ID of the request it answers, so several masters sharing the port can each pick out their own traffic. A read returns the addressed register. A write updates only the enabled bytes and returns zero data. Addresses outside the bank read as zero, and writes to them change nothing. Both still get a response.

The bank size must be a power of two. Word index bits sit just above the two byte-offset bits of the address. Every address bit above the index must be zero for an access to hit the bank.

Top module: `cfg_regbank`

## Requirements
- R1: `gnt_o` equals `req_i` in the same cycle; a request is accepted in any cycle where both are high.
- R2: An accepted request makes `rvalid_o` high for exactly the following cycle. `rvalid_o` is low in a cycle that does not follow an accepted request. This holds for reads and writes alike, including back-to-back requests.
- R3: With each response, `rid_o` returns the `id_i` value of the request being answered.
- R4: `we_n_i` = 1 selects a read and `we_n_i` = 0 selects a write. A read of a mapped address returns the current content of register `addr_i[5:2]` on `rdata_o` with the response. There are 16 registers at the default size.
- R5: A write to a mapped address changes only the bytes whose enable is set, where `be_i[k]` covers data bits `8k+7:8k`. A write with all enables clear changes nothing.
- R6: The response to a write carries `rdata_o` = 0.
- R7: An address with any of bits 31:6 set is unmapped. A read of it returns 0, and a write to it leaves every register unchanged, even the one whose index matches its bits 5:2.
- R8: Reset clears all registers, `rvalid_o`, `rid_o` and `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request from master |
| gnt_o | output | 1 | Grant, combinational from request |
| addr_i | input | 32 | Byte address, word aligned |
| we_n_i | input | 1 | 1 = read, 0 = write |
| be_i | input | 4 | Byte enables for writes |
| wdata_i | input | 32 | Write data |
| id_i | input | 8 | Requester ID |
| rdata_o | output | 32 | Read data of the response |
| rvalid_o | output | 1 | Response strobe |
| rid_o | output | 8 | Echoed requester ID |

## Verification
The hardest case to reach from the ports is a continuous stream of requests. There, each cycle's response must carry the previous request's ID and data while a new request is already being accepted. The stimulus table is therefore driven back to back with no idle cycles, so every response overlaps a new request with a different ID.

A write to the unmapped alias of register 0 is also hard to observe, because it produces no visible effect. It is followed by a read of register 0 to show that the write was discarded.

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int IDW  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  output logic           gnt_o,
  input  logic [AW-1:0]  addr_i,
  input  logic           we_n_i,
  input  logic [DW/8-1:0] be_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [IDW-1:0] id_i,
  output logic [DW-1:0]  rdata_o,
  output logic           rvalid_o,
  output logic [IDW-1:0] rid_o
);
  localparam int NB  = DW / 8;
  localparam int OFF = $clog2(NB);
  localparam int IW  = $clog2(NREG);

  logic [DW-1:0] regs [NREG];
  logic [IW-1:0] idx;
  logic          hit, acc, unused_low;

  assign gnt_o      = req_i;
  assign acc        = req_i & gnt_o;
  assign idx        = addr_i[OFF +: IW];
  assign hit        = (addr_i[AW-1:OFF+IW] == '0);
  assign unused_low = ^addr_i[OFF-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else if (acc && !we_n_i && hit) begin
      for (int b = 0; b < NB; b++)
        if (be_i[b]) regs[idx][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rid_o    <= '0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= acc;
      rid_o    <= acc ? id_i : '0;
      rdata_o  <= (acc && we_n_i && hit) ? regs[idx] : '0;
    end
  end
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int IDW  = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           gnt_o,
  input logic [AW-1:0]  addr_i,
  input logic           we_n_i,
  input logic [IDW-1:0] id_i,
  input logic [DW-1:0]  rdata_o,
  input logic           rvalid_o,
  input logic [IDW-1:0] rid_o
);
  localparam int TOP = $clog2(DW / 8) + $clog2(NREG);

  always_comb AST_GNT_FOLLOWS_REQ: assert (gnt_o == req_i); // R1

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni) // R2
    (req_i && gnt_o) |=> rvalid_o);

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni) // R2
    !(req_i && gnt_o) |=> !rvalid_o);

  AST_ID_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni) // R3
    (req_i && gnt_o) |=> (rid_o == $past(id_i)));

  AST_WRITE_RSP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) // R6
    (req_i && gnt_o && !we_n_i) |=> (rdata_o == '0));

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) // R7
    (req_i && gnt_o && we_n_i && (addr_i[AW-1:TOP] != '0)) |=> (rdata_o == '0));
endmodule

bind cfg_regbank cfg_regbank_chk #(.NREG(NREG), .AW(AW), .DW(DW), .IDW(IDW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .gnt_o(gnt_o), .addr_i(addr_i),
  .we_n_i(we_n_i), .id_i(id_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .rid_o(rid_o)
);

// File: tb/test_cfg_regbank.sv
module test_cfg_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        gnt;
  logic [31:0] addr = '0;
  logic        we_n = 1'b1;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  id = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [7:0]  rid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cfg_regbank i_cfg_regbank (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gnt_o(gnt), .addr_i(addr),
    .we_n_i(we_n), .be_i(be), .wdata_i(wdata), .id_i(id),
    .rdata_o(rdata), .rvalid_o(rvalid), .rid_o(rid)
  );

  // {we_n, addr, be, wdata, id, expected rdata, requirement tag}
  localparam int NV = 13;
  localparam logic [108:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 4'hF, 32'h1122_3344, 8'h01, 32'h0000_0000},
    {1'b1, 32'h0000_0000, 4'h0, 32'h0000_0000, 8'h02, 32'h1122_3344},
    {1'b0, 32'h0000_0000, 4'h5, 32'hAABB_CCDD, 8'h03, 32'h0000_0000},
    {1'b1, 32'h0000_0000, 4'h0, 32'h0000_0000, 8'h04, 32'h11BB_33DD},
    {1'b0, 32'h0000_003C, 4'h8, 32'h5A00_0000, 8'h05, 32'h0000_0000},
    {1'b1, 32'h0000_003C, 4'h0, 32'h0000_0000, 8'h06, 32'h5A00_0000},
    {1'b0, 32'h0000_0040, 4'hF, 32'hFFFF_FFFF, 8'h07, 32'h0000_0000},
    {1'b1, 32'h0000_0000, 4'h0, 32'h0000_0000, 8'h08, 32'h11BB_33DD},
    {1'b1, 32'h0000_0040, 4'h0, 32'h0000_0000, 8'h09, 32'h0000_0000},
    {1'b1, 32'h8000_0000, 4'h0, 32'h0000_0000, 8'hFF, 32'h0000_0000},
    {1'b0, 32'h0000_0004, 4'h0, 32'h1234_5678, 8'h0A, 32'h0000_0000},
    {1'b1, 32'h0000_0004, 4'h0, 32'h0000_0000, 8'h0B, 32'h0000_0000},
    {1'b1, 32'h0000_003C, 4'h0, 32'h0000_0000, 8'h0C, 32'h5A00_0000}
  };
  localparam string TAG [NV] = '{"R5", "R4", "R5", "R5", "R5", "R4", "R6",
                                 "R7", "R7", "R7", "R5", "R5", "R4"};

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [108:0] v);
    req   = 1'b1;
    we_n  = v[108];
    addr  = v[107:76];
    be    = v[75:72];
    wdata = v[71:40];
    id    = v[39:32];
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(rvalid == 1'b0 && rid == 8'h00 && rdata == 32'h0, "R8 reset outputs",
          {23'h0, rvalid, rid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    check(gnt == 1'b0, "R1 grant idle", {31'h0, gnt}, 32'h0);
    req = 1'b1;
    #1;
    check(gnt == 1'b1, "R1 grant with request", {31'h0, gnt}, 32'h1);
    req = 1'b0;

    // back-to-back walk: each cycle checks the previous response
    for (int i = 0; i <= NV; i++) begin
      if (i > 0) begin
        check(rvalid == 1'b1, "R2 response strobe", {31'h0, rvalid}, 32'h1);
        check(rid == VEC[i-1][39:32], "R3 id echo", {24'h0, rid}, {24'h0, VEC[i-1][39:32]});
        check(rdata == VEC[i-1][31:0], TAG[i-1], rdata, VEC[i-1][31:0]);
      end
      if (i < NV) drive(VEC[i]);
      else req = 1'b0;
      @(negedge clk);
    end
    check(rvalid == 1'b0, "R2 no response when idle", {31'h0, rvalid}, 32'h0);

    // single write, then idle gap, then read
    drive({1'b0, 32'h0000_0020, 4'h3, 32'hDEAD_BEEF, 8'h3C, 32'h0});
    @(negedge clk);
    req = 1'b0;
    check(rvalid == 1'b1 && rid == 8'h3C, "R2 write response", {23'h0, rvalid, rid}, 32'h13C);
    check(rdata == 32'h0, "R6 write response data", rdata, 32'h0);
    @(negedge clk);
    check(rvalid == 1'b0, "R2 single-cycle strobe", {31'h0, rvalid}, 32'h0);
    drive({1'b1, 32'h0000_0020, 4'h0, 32'h0, 8'h3D, 32'h0});
    @(negedge clk);
    req = 1'b0;
    check(rdata == 32'h0000_BEEF && rid == 8'h3D, "R5 low half write", rdata, 32'h0000_BEEF);

    // reset mid-run clears registers
    rst_n = 1'b0;
    @(negedge clk);
    check(rvalid == 1'b0 && rdata == 32'h0 && rid == 8'h0, "R8 reset clears response",
          rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    drive({1'b1, 32'h0000_0000, 4'h0, 32'h0, 8'h55, 32'h0});
    @(negedge clk);
    req = 1'b0;
    check(rdata == 32'h0, "R8 register 0 cleared", rdata, 32'h0);
    drive({1'b1, 32'h0000_003C, 4'h0, 32'h0, 8'h56, 32'h0});
    @(negedge clk);
    req = 1'b0;
    check(rdata == 32'h0, "R8 register 15 cleared", rdata, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule